// File: doc/BRIEF.md
# Scan-Wrapped Datapath Register Bank

This block holds the data registers of an iterative cipher datapath: a block-wide plaintext staging register and the two half-width round registers, called left and right. Each of these bits is a mux-D scan cell. With `scan_mode` low, the cells behave as ordinary enabled registers, and the surrounding round logic reads and writes them. With `scan_mode` high, every cell drops its functional input and takes the output of its neighbour instead. The cells then form one serial chain from `scan_in` to `scan_out`, which a tester uses to load and unload the whole state.

The cells are stitched in a fixed scrambled order, as placement would leave them, and not in bit order. Position p of the chain (p = 0 is the cell fed by `scan_in`) holds flat bit (STRIDE·p + START) mod CHAIN_LEN. In the flat numbering, left bits come first, then right bits, then plaintext bits. The key register sits in the same wrapper but is a plain register that is never on the chain, so a scan unload cannot carry key material out.

Top module: `scan_reg_wrapper`

## Requirements
- R1: A synchronous active-high `rst` clears `pt_q`, `l_q`, `r_q`, `key_q` and `scan_out` to zero at the next rising edge.
- R2: With `scan_mode` = 0, an edge with `pt_en` = 1 loads `pt_d` into `pt_q`. An edge with `pt_en` = 0 leaves `pt_q` unchanged.
- R3: With `scan_mode` = 0, an edge with `lr_en` = 1 loads `l_d` into `l_q` and `r_d` into `r_q`. An edge with `lr_en` = 0 leaves both unchanged.
- R4: With `scan_mode` = 1, every chained cell takes the value of its predecessor and the first cell takes `scan_in`. `pt_en`, `lr_en`, `pt_d`, `l_d` and `r_d` have no effect on that edge.
- R5: Chain position p holds flat bit (73·p + 12) mod 128. Flat bits 0..31 are `l_q[0..31]`, 32..63 are `r_q[0..31]`, and 64..127 are `pt_q[0..63]`. So `l_q[12]` is next to `scan_in`, and `pt_q[3]` is the last cell, whose output is `scan_out`.
- R6: In unbroken shift mode, the `scan_in` value sampled at one edge appears on `scan_out` after the 128th shift edge, counting that edge.
- R7: `key_en` = 1 loads `key_d` into `key_q` in either mode, and `key_en` = 0 holds it. The key register is not on the chain, so neither `key_q` nor `key_d` ever affects `scan_out` or the chained registers.
- R8: Each edge uses only the `scan_mode` value present at that edge. Any edge-by-edge mix of capture and shift edges gives the per-edge results of R2 to R4, with no bit lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_mode | input | 1 | 1 = shift chain, 0 = functional capture |
| scan_in | input | 1 | Serial input to chain position 0 |
| scan_out | output | 1 | Output of the last chain cell |
| pt_en | input | 1 | Plaintext register load enable (functional mode) |
| pt_d | input | DATA_W | Plaintext register functional input |
| pt_q | output | DATA_W | Plaintext register contents |
| lr_en | input | 1 | Left/right register load enable (functional mode) |
| l_d | input | DATA_W/2 | Left register functional input |
| r_d | input | DATA_W/2 | Right register functional input |
| l_q | output | DATA_W/2 | Left register contents |
| r_q | output | DATA_W/2 | Right register contents |
| key_en | input | 1 | Key register load enable |
| key_d | input | KEY_W | Key register input |
| key_q | output | KEY_W | Key register contents |

## Verification
Two functions can fall in the same edge: a shift, and the functional enables with fresh data on the D inputs. The bench holds `pt_en` and `lr_en` high with random data throughout the shift phases, and it loads new keys during shifts. A behavioural model keeps only the register values and rebuilds the chain as a queue in the stated order. Every edge is judged by comparing all outputs against that model, so any capture that leaks into a shift edge, or any key bit that reaches the stream, shows up as a mismatch. A final phase toggles `scan_mode` at random from edge to edge to test the per-edge choice between capture and shift.

// File: rtl/scan_wrap_pkg.sv
`timescale 1ns/1ps
package scan_wrap_pkg;

  // Register groups in the flat numbering: left, right, plaintext.
  typedef enum logic [1:0] {GRP_LEFT, GRP_RIGHT, GRP_PLAIN} reg_grp_e;

  // Flat bit index held by a chain position (position 0 follows scan_in).
  // Bijective when len is a power of two and stride is odd.
  function automatic int unsigned chain_slot_src(input int unsigned pos,
                                                 input int unsigned len,
                                                 input int unsigned stride,
                                                 input int unsigned start);
    return (stride * pos + start) % len;
  endfunction

  function automatic reg_grp_e flat_group(input int unsigned idx,
                                          input int unsigned half);
    if (idx < half)          return GRP_LEFT;
    else if (idx < 2 * half) return GRP_RIGHT;
    else                     return GRP_PLAIN;
  endfunction

endpackage

// File: rtl/scan_mux_cell.sv
`timescale 1ns/1ps
module scan_mux_cell (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic si,
  input  logic fen,
  input  logic fd,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (mode) q <= si;
    else if (fen)  q <= fd;
  end

  // Shift edge takes the neighbour, never functional data.
  assert_shift_takes_si_R4: assert property (@(posedge clk) disable iff (rst)
    mode |=> (q == $past(si)));

  // Capture edge takes functional data.
  assert_capture_takes_d_R8: assert property (@(posedge clk) disable iff (rst)
    (!mode && fen) |=> (q == $past(fd)));

  // Idle functional edge holds.
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!mode && !fen) |=> $stable(q));

endmodule

// File: rtl/scan_chain_core.sv
`timescale 1ns/1ps
module scan_chain_core #(
  parameter int unsigned LEN    = 128,
  parameter int unsigned STRIDE = 73,
  parameter int unsigned START  = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode,
  input  logic           scan_in,
  input  logic [LEN-1:0] flat_d,
  input  logic [LEN-1:0] flat_en,
  output logic [LEN-1:0] flat_q,
  output logic           scan_out
);

  logic [LEN-1:0] chain_q;

  for (genvar p = 0; p < LEN; p++) begin : g_cell
    localparam int unsigned IDX =
      scan_wrap_pkg::chain_slot_src(p, LEN, STRIDE, START);
    logic si_w;
    if (p == 0) begin : g_head
      assign si_w = scan_in;
    end else begin : g_body
      assign si_w = chain_q[p-1];
    end
    scan_mux_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .si   (si_w),
      .fen  (flat_en[IDX]),
      .fd   (flat_d[IDX]),
      .q    (chain_q[p])
    );
    assign flat_q[IDX] = chain_q[p];
  end

  assign scan_out = chain_q[LEN-1];

  // Tail cell output moves out one place per shift edge.
  assert_tail_advance_R6: assert property (@(posedge clk) disable iff (rst)
    mode |=> (scan_out == $past(chain_q[LEN-2])));

  // Head cell takes the serial input on shift edges.
  assert_head_loads_R4: assert property (@(posedge clk) disable iff (rst)
    mode |=> (chain_q[0] == $past(scan_in)));

endmodule

// File: rtl/key_hold_reg.sv
`timescale 1ns/1ps
module key_hold_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  assert_key_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  assert_key_loads_R7: assert property (@(posedge clk) disable iff (rst)
    en |=> (q == $past(d)));

endmodule

// File: rtl/scan_reg_wrapper.sv
`timescale 1ns/1ps
module scan_reg_wrapper #(
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned KEY_W        = 64,
  parameter int unsigned ORDER_STRIDE = 73,
  parameter int unsigned ORDER_START  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scan_mode,
  input  logic                  scan_in,
  output logic                  scan_out,
  input  logic                  pt_en,
  input  logic [DATA_W-1:0]     pt_d,
  output logic [DATA_W-1:0]     pt_q,
  input  logic                  lr_en,
  input  logic [DATA_W/2-1:0]   l_d,
  input  logic [DATA_W/2-1:0]   r_d,
  output logic [DATA_W/2-1:0]   l_q,
  output logic [DATA_W/2-1:0]   r_q,
  input  logic                  key_en,
  input  logic [KEY_W-1:0]      key_d,
  output logic [KEY_W-1:0]      key_q
);

  localparam int unsigned HALF      = DATA_W / 2;
  localparam int unsigned CHAIN_LEN = 2 * DATA_W;

  logic [CHAIN_LEN-1:0] flat_d, flat_en, flat_q;

  // Flat numbering: left low, then right, then plaintext.
  assign flat_d  = {pt_d, r_d, l_d};
  assign flat_en = {{DATA_W{pt_en}}, {DATA_W{lr_en}}};

  scan_chain_core #(
    .LEN    (CHAIN_LEN),
    .STRIDE (ORDER_STRIDE),
    .START  (ORDER_START)
  ) u_chain (
    .clk      (clk),
    .rst      (rst),
    .mode     (scan_mode),
    .scan_in  (scan_in),
    .flat_d   (flat_d),
    .flat_en  (flat_en),
    .flat_q   (flat_q),
    .scan_out (scan_out)
  );

  assign l_q  = flat_q[HALF-1:0];
  assign r_q  = flat_q[2*HALF-1:HALF];
  assign pt_q = flat_q[CHAIN_LEN-1:2*HALF];

  key_hold_reg #(.W(KEY_W)) u_key (
    .clk (clk),
    .rst (rst),
    .en  (key_en),
    .d   (key_d),
    .q   (key_q)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pt_q == '0 && l_q == '0 && r_q == '0 && key_q == '0 && !scan_out));

  // In shift mode the plaintext and round registers ignore their enables.
  assert_shift_ignores_load_R4: assert property (@(posedge clk) disable iff (rst)
    (scan_mode && pt_en && lr_en) |=> ($countones({pt_q, l_q, r_q}) ==
      $countones($past({pt_q, l_q, r_q})) - $past(scan_out) + $past(scan_in)));

endmodule

// File: tb/scan_reg_wrapper_bench.sv
`timescale 1ns/1ps
module scan_reg_wrapper_bench;

  localparam int DW  = 64;
  localparam int HW  = 32;
  localparam int KW  = 64;
  localparam int LEN = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, scan_mode = 1'b0, scan_in = 1'b0;
  logic          pt_en = 1'b0, lr_en = 1'b0, key_en = 1'b0;
  logic [DW-1:0] pt_d = '0;
  logic [HW-1:0] l_d = '0, r_d = '0;
  logic [KW-1:0] key_d = '0;
  logic          scan_out;
  logic [DW-1:0] pt_q;
  logic [HW-1:0] l_q, r_q;
  logic [KW-1:0] key_q;

  scan_reg_wrapper u_scan_reg_wrapper (
    .clk(clk), .rst(rst), .scan_mode(scan_mode), .scan_in(scan_in),
    .scan_out(scan_out), .pt_en(pt_en), .pt_d(pt_d), .pt_q(pt_q),
    .lr_en(lr_en), .l_d(l_d), .r_d(r_d), .l_q(l_q), .r_q(r_q),
    .key_en(key_en), .key_d(key_d), .key_q(key_q)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference state
  logic [DW-1:0] m_pt = '0;
  logic [HW-1:0] m_l = '0, m_r = '0;
  logic [KW-1:0] m_key = '0;
  bit pend[$];

  function automatic int slot_of(input int pos);
    return (73 * pos + 12) % LEN;
  endfunction

  function automatic logic get_flat(input int idx);
    if (idx < HW)      return m_l[idx];
    else if (idx < DW) return m_r[idx - HW];
    else               return m_pt[idx - DW];
  endfunction

  task automatic set_flat(input int idx, input logic v);
    if (idx < HW)      m_l[idx] = v;
    else if (idx < DW) m_r[idx - HW] = v;
    else               m_pt[idx - DW] = v;
  endtask

  function automatic logic exp_scan_out();
    return get_flat(slot_of(LEN - 1));
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_pt = '0; m_l = '0; m_r = '0; m_key = '0;
    end else begin
      if (scan_mode) begin
        bit line[$];
        for (int p = 0; p < LEN; p++) line.push_back(get_flat(slot_of(p)));
        line.push_front(scan_in);
        void'(line.pop_back());
        for (int p = 0; p < LEN; p++) set_flat(slot_of(p), line[p]);
      end else begin
        if (pt_en) m_pt = pt_d;
        if (lr_en) begin m_l = l_d; m_r = r_d; end
      end
      if (key_en) m_key = key_d;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "pt_q", pt_q, m_pt);
    check(tag, "l_q", {32'h0, l_q}, {32'h0, m_l});
    check(tag, "r_q", {32'h0, r_q}, {32'h0, m_r});
    check(tag, "key_q", key_q, m_key);
    check(tag, "scan_out", {63'h0, scan_out}, {63'h0, exp_scan_out()});
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    compare_all(tag);
  endtask

  task automatic rand_func();
    pt_d = {$urandom, $urandom};
    l_d  = $urandom;
    r_d  = $urandom;
  endtask

  initial begin
    #1;
    // R1: reset
    tick("R1"); tick("R1");
    check("R1", "scan_out reset", {63'h0, scan_out}, 64'h0);
    rst = 1'b0;

    // R2: plaintext capture and hold
    pt_d = 64'h0123_4567_89AB_CDEF; pt_en = 1'b1;
    tick("R2");
    check("R2", "pt loaded", pt_q, 64'h0123_4567_89AB_CDEF);
    pt_en = 1'b0; pt_d = 64'hFFFF_0000_FFFF_0000;
    tick("R2");
    check("R2", "pt held", pt_q, 64'h0123_4567_89AB_CDEF);

    // R3: left/right capture and hold
    l_d = 32'hDEAD_BEEF; r_d = 32'h1357_9BDF; lr_en = 1'b1;
    tick("R3");
    check("R3", "l loaded", {32'h0, l_q}, 64'h0000_0000_DEAD_BEEF);
    lr_en = 1'b0; l_d = 32'h0; r_d = 32'h0;
    tick("R3");
    check("R3", "r held", {32'h0, r_q}, 64'h0000_0000_1357_9BDF);

    // R7: key load in functional mode
    key_d = 64'hA5A5_5A5A_C3C3_3C3C; key_en = 1'b1;
    tick("R7");
    key_en = 1'b0;
    tick("R7");
    check("R7", "key held", key_q, 64'hA5A5_5A5A_C3C3_3C3C);

    // R5: last cell is pt bit 3 after a capture
    pt_d = 64'h0000_0000_0000_0008; pt_en = 1'b1;
    tick("R5");
    pt_en = 1'b0;
    #1;
    check("R5", "scan_out is pt[3]", {63'h0, scan_out}, 64'h1);

    // R4/R5/R7: unload with enables active and keys loading during shift
    scan_mode = 1'b1; pt_en = 1'b1; lr_en = 1'b1;
    pend.delete();
    for (int k = 0; k < 2 * LEN; k++) begin
      rand_func();
      scan_in = $urandom_range(0, 1);
      key_en = (k % 5 == 0);
      key_d = {$urandom, $urandom};
      pend.push_back(scan_in);
      tick("R4");
      // R6: serial bit emerges after 128 shift edges
      if (pend.size() == LEN) begin
        bit b;
        b = pend.pop_front();
        check("R6", "scan_out delay", {63'h0, scan_out}, {63'h0, b});
      end
    end
    key_en = 1'b0;

    // R8: per-edge mode changes with mixed activity
    for (int k = 0; k < 400; k++) begin
      scan_mode = $urandom_range(0, 1);
      pt_en  = $urandom_range(0, 1);
      lr_en  = $urandom_range(0, 1);
      key_en = $urandom_range(0, 1);
      scan_in = $urandom_range(0, 1);
      key_d = {$urandom, $urandom};
      rand_func();
      tick("R8");
    end

    // R1: reset in the middle of shifting
    scan_mode = 1'b1; rst = 1'b1;
    tick("R1");
    rst = 1'b0; scan_mode = 1'b0; pt_en = 1'b0; lr_en = 1'b0; key_en = 1'b0;
    tick("R1");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule